// File: doc/BRIEF.md
# Zero-Address Stack Execution Unit

This block executes a small instruction stream in which arithmetic carries no address. Operands for add, subtract and multiply come from an on-chip hardware stack, and each result goes back onto that stack. Only two instructions carry an address. Load-to-stack reads a word from an external word-addressed data memory and puts it on top of the stack. Store-from-stack takes the top entry off the stack and writes it to memory.

Instructions arrive as an opcode and an address under a valid/ready handshake, and the unit completes one instruction every two cycles. It reports the current top-of-stack value and pulses a completion strobe for every instruction. Two sticky error flags record stack overflow and stack underflow, and only reset clears them. The data memory is outside the block and is reached through a simple port with a one-cycle read latency.

Top module: `zstk_unit`

## Requirements
- R1: After reset, `top_data` is 0, `in_ready` is 1, and `done`, `ovf_flag` and `unf_flag` are 0. The stack is empty.
- R2: Opcode 0 (load-to-stack) reads memory at `in_addr` and puts the word on top of the stack. The read request is issued in the cycle the instruction is accepted, and `mem_rdata` is taken one cycle later.
- R3: Opcode 1 (store-from-stack) writes the top entry to memory at `in_addr` and removes that entry from the stack.
- R4: Opcode 2 removes the two top entries and pushes their sum modulo 2^16.
- R5: Opcode 3 removes the two top entries and pushes (second-from-top minus top) modulo 2^16.
- R6: Opcode 4 removes the two top entries and pushes the low 16 bits of their product.
- R7: The stack holds 8 entries. A load-to-stack on a full stack sets the sticky `ovf_flag` and leaves the stack unchanged.
- R8: An arithmetic opcode with fewer than two entries, or a store-from-stack on an empty stack, sets the sticky `unf_flag`. In both cases the stack is unchanged and no memory write is issued.
- R9: An instruction accepted at clock edge n drives `in_ready` low until edge n+1. `done` is high for exactly one cycle, starting at edge n+2. At that point `top_data` and the flags already show the instruction's effect, and `in_ready` is high again.
- R10: Opcodes 5 to 7 complete with `done` and have no effect on the stack, the flags or memory. Arithmetic opcodes ignore `in_addr`.
- R11: The sequence load C, load D, mul, load B, add, load E, sub, load F, add, load A, add, store A leaves B+C*D-E+F+A (mod 2^16) in location A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Unit can accept an instruction |
| in_op | input | 3 | Opcode |
| in_addr | input | AW | Memory address for load/store |
| mem_en | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | W | Memory write data |
| mem_rdata | input | W | Memory read data, one cycle after request |
| top_data | output | W | Current top of stack, 0 when empty |
| done | output | 1 | One-cycle completion pulse |
| ovf_flag | output | 1 | Sticky overflow flag |
| unf_flag | output | 1 | Sticky underflow flag |

## Verification
The bench builds the unit with its default parameters: 16-bit words, an 8-entry stack and an 8-bit memory address. With a stack that shallow, a random instruction stream weighted toward loads reaches the full and empty boundaries within a few instructions. With 16-bit words, random operands exercise the wrap of sums and differences and the truncation of products. A 256-word memory lets random addresses collide, so a load often reads back a word that an earlier store wrote.

// File: rtl/zstk_pkg.sv
package zstk_pkg;

  localparam logic [2:0] OP_PUSH = 3'd0;
  localparam logic [2:0] OP_POP  = 3'd1;
  localparam logic [2:0] OP_ADD  = 3'd2;
  localparam logic [2:0] OP_SUB  = 3'd3;
  localparam logic [2:0] OP_MUL  = 3'd4;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_EXEC = 1'b1
  } zstk_state_e;

  function automatic logic is_arith(input logic [2:0] op);
    return (op == OP_ADD) || (op == OP_SUB) || (op == OP_MUL);
  endfunction

endpackage

// File: rtl/zstk_alu.sv
module zstk_alu
  import zstk_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [2:0]   op,
  input  logic [W-1:0] lhs,
  input  logic [W-1:0] rhs,
  output logic [W-1:0] res
);

  always_comb begin
    case (op)
      OP_ADD:  res = lhs + rhs;
      OP_SUB:  res = lhs - rhs;
      OP_MUL:  res = lhs * rhs;
      default: res = '0;
    endcase
  end

endmodule

// File: rtl/zstk_store.sv
module zstk_store #(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [W-1:0]  wr_data,
  input  logic [CW-1:0] cnt,
  output logic [W-1:0]  top_val,
  output logic [W-1:0]  next_val
);

  logic [W-1:0] ent [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (wr_en && (wr_idx == IW'(g))) begin
        ent[g] <= wr_data;
      end
    end
  end

  always_comb begin
    top_val  = '0;
    next_val = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (int'(cnt) == i + 1) top_val  = ent[i];
      if (int'(cnt) == i + 2) next_val = ent[i];
    end
  end

  AST_WR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (int'(wr_idx) < DEPTH)); // R7

endmodule

// File: rtl/zstk_ctrl.sv
module zstk_ctrl
  import zstk_pkg::*;
#(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  parameter int AW    = 8,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [2:0]    in_op,
  input  logic [AW-1:0] in_addr,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [W-1:0]  mem_wdata,
  input  logic [W-1:0]  mem_rdata,
  input  logic [W-1:0]  top_val,
  input  logic [W-1:0]  alu_res,
  output logic [2:0]    alu_op,
  output logic          wr_en,
  output logic [IW-1:0] wr_idx,
  output logic [W-1:0]  wr_data,
  output logic [CW-1:0] cnt,
  output logic          done,
  output logic          ovf_flag,
  output logic          unf_flag
);

  zstk_state_e   state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          ovf_q, ovf_d;
  logic          unf_q, unf_d;
  logic          done_q, done_d;
  logic [2:0]    op_q;
  logic [AW-1:0] addr_q;

  logic accept, full, have1, have2, in_exec, pop_ok;

  assign in_exec  = (state_q == ST_EXEC);
  assign in_ready = (state_q == ST_IDLE);
  assign accept   = in_valid && in_ready;
  assign full     = (int'(cnt_q) == DEPTH);
  assign have1    = (cnt_q != '0);
  assign have2    = (int'(cnt_q) >= 2);
  assign pop_ok   = in_exec && (op_q == OP_POP) && have1;

  // Memory port: read issued in the accept cycle, write in the execute cycle
  assign mem_en    = (accept && (in_op == OP_PUSH) && !full) || pop_ok;
  assign mem_we    = pop_ok;
  assign mem_addr  = in_exec ? addr_q : in_addr;
  assign mem_wdata = top_val;
  assign alu_op    = op_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    ovf_d   = ovf_q;
    unf_d   = unf_q;
    done_d  = in_exec;
    wr_en   = 1'b0;
    wr_idx  = '0;
    wr_data = mem_rdata;
    case (state_q)
      ST_IDLE: begin
        if (in_valid) state_d = ST_EXEC;
      end
      ST_EXEC: begin
        state_d = ST_IDLE;
        if (op_q == OP_PUSH) begin
          if (full) begin
            ovf_d = 1'b1;
          end else begin
            wr_en   = 1'b1;
            wr_idx  = IW'(cnt_q);
            wr_data = mem_rdata;
            cnt_d   = cnt_q + CW'(1);
          end
        end else if (op_q == OP_POP) begin
          if (!have1) unf_d = 1'b1;
          else        cnt_d = cnt_q - CW'(1);
        end else if (is_arith(op_q)) begin
          if (!have2) begin
            unf_d = 1'b1;
          end else begin
            wr_en   = 1'b1;
            wr_idx  = IW'(cnt_q - CW'(2));
            wr_data = alu_res;
            cnt_d   = cnt_q - CW'(1);
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      ovf_q   <= 1'b0;
      unf_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      ovf_q   <= ovf_d;
      unf_q   <= unf_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      op_q   <= in_op;
      addr_q <= in_addr;
    end
  end

  assign cnt      = cnt_q;
  assign done     = done_q;
  assign ovf_flag = ovf_q;
  assign unf_flag = unf_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) <= DEPTH); // R7
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q); // R7
  AST_UNF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    unf_q |=> unf_q); // R8
  AST_WRITE_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> have1); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R9
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (!in_ready ##1 done_q)); // R9
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + CW'(1)) ||
    (cnt_q == $past(cnt_q) - CW'(1))); // R2

endmodule

// File: rtl/zstk_unit.sv
module zstk_unit
  import zstk_pkg::*;
#(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [2:0]    in_op,
  input  logic [AW-1:0] in_addr,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [W-1:0]  mem_wdata,
  input  logic [W-1:0]  mem_rdata,
  output logic [W-1:0]  top_data,
  output logic          done,
  output logic          ovf_flag,
  output logic          unf_flag
);

  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  // Reset synchronizer: asserts at once, releases on the clock
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic          wr_en;
  logic [IW-1:0] wr_idx;
  logic [W-1:0]  wr_data;
  logic [CW-1:0] cnt;
  logic [W-1:0]  top_val, next_val, alu_res;
  logic [2:0]    alu_op;

  zstk_ctrl #(.W(W), .DEPTH(DEPTH), .AW(AW)) i_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_op     (in_op),
    .in_addr   (in_addr),
    .mem_en    (mem_en),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .top_val   (top_val),
    .alu_res   (alu_res),
    .alu_op    (alu_op),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .cnt       (cnt),
    .done      (done),
    .ovf_flag  (ovf_flag),
    .unf_flag  (unf_flag)
  );

  zstk_store #(.W(W), .DEPTH(DEPTH)) i_store (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .cnt      (cnt),
    .top_val  (top_val),
    .next_val (next_val)
  );

  zstk_alu #(.W(W)) i_alu (
    .op  (alu_op),
    .lhs (next_val),
    .rhs (top_val),
    .res (alu_res)
  );

  assign top_data = top_val;

endmodule

// File: tb/test_zstk_unit.sv
module test_zstk_unit;

  localparam int W = 16;
  localparam int DEPTH = 8;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [2:0]    in_op = '0;
  logic [AW-1:0] in_addr = '0;
  logic          mem_en, mem_we;
  logic [AW-1:0] mem_addr;
  logic [W-1:0]  mem_wdata;
  logic [W-1:0]  mem_rdata = '0;
  logic [W-1:0]  top_data;
  logic          done, ovf_flag, unf_flag;

  always #2 clk = ~clk;

  zstk_unit #(.W(W), .DEPTH(DEPTH), .AW(AW)) i_zstk_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_addr(in_addr), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .top_data(top_data), .done(done), .ovf_flag(ovf_flag), .unf_flag(unf_flag)
  );

  // Data memory model, one-cycle read latency
  logic [W-1:0] mem [1 << AW];
  int wr_count = 0;
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) begin
        mem[mem_addr] <= mem_wdata;
        wr_count <= wr_count + 1;
      end else begin
        mem_rdata <= mem[mem_addr];
      end
    end
  end

  // Reference model
  logic [W-1:0] m_stk [DEPTH];
  int m_cnt;
  bit m_ovf, m_unf;
  int n_tests = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  function automatic logic [W-1:0] f_alu(input logic [2:0] op, input logic [W-1:0] a,
                                         input logic [W-1:0] b);
    logic [31:0] p;
    case (op)
      3'd2: return a + b;
      3'd3: return a - b;
      default: begin p = a * b; return p[W-1:0]; end
    endcase
  endfunction

  function automatic logic [W-1:0] f_top();
    return (m_cnt == 0) ? '0 : m_stk[m_cnt-1];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    m_cnt = 0; m_ovf = 0; m_unf = 0;
  endtask

  // Runs one instruction; called at a negedge with the unit idle
  task automatic run_op(input logic [2:0] op, input logic [AW-1:0] addr, input string req);
    logic [W-1:0] popped;
    int wc0;
    bit did_pop;
    did_pop = 0;
    popped = '0;
    wc0 = wr_count;
    case (op)
      3'd0: if (m_cnt == DEPTH) m_ovf = 1;
            else begin m_stk[m_cnt] = mem[addr]; m_cnt++; end
      3'd1: if (m_cnt == 0) m_unf = 1;
            else begin popped = m_stk[m_cnt-1]; m_cnt--; did_pop = 1; end
      3'd2, 3'd3, 3'd4:
            if (m_cnt < 2) m_unf = 1;
            else begin
              m_stk[m_cnt-2] = f_alu(op, m_stk[m_cnt-2], m_stk[m_cnt-1]);
              m_cnt--;
            end
      default: ;
    endcase
    in_valid = 1'b1; in_op = op; in_addr = addr;
    @(negedge clk);
    chk(in_ready == 1'b0, "R9 busy", {31'b0, in_ready}, 32'd0);
    in_valid = 1'b0;
    @(negedge clk);
    chk(done == 1'b1 && in_ready == 1'b1, "R9 done", {30'b0, done, in_ready}, 32'd3);
    chk(top_data == f_top(), req, top_data, f_top());
    chk(ovf_flag == m_ovf, "R7 ovf", ovf_flag, m_ovf);
    chk(unf_flag == m_unf, "R8 unf", unf_flag, m_unf);
    if (did_pop) chk(mem[addr] == popped, "R3 store", mem[addr], popped);
    else chk(wr_count == wc0, "R8/R10 no write", wr_count, wc0);
  endtask

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < (1 << AW); i++) mem[i] = W'($urandom);
    do_reset();
    // R1 reset state
    chk(top_data == 0 && in_ready && !done && !ovf_flag && !unf_flag, "R1 reset",
        {top_data, 11'b0, in_ready, done, ovf_flag, unf_flag}, 32'h0000_0008);

    // R8 underflow corners
    run_op(3'd1, 8'd3, "R8 pop empty");
    do_reset();
    run_op(3'd0, 8'd5, "R2 push");
    run_op(3'd2, 8'd0, "R8 add one entry");
    do_reset();

    // R7 fill then overflow
    for (int i = 0; i < DEPTH; i++) run_op(3'd0, 8'(i + 20), "R2 fill");
    run_op(3'd0, 8'd40, "R7 push full");
    run_op(3'd5, 8'd41, "R10 op5 no effect");
    run_op(3'd7, 8'd42, "R10 op7 no effect");
    run_op(3'd4, 8'd200, "R6 mul");
    run_op(3'd3, 8'd201, "R5 sub");
    run_op(3'd2, 8'd202, "R4 add");
    run_op(3'd1, 8'd50, "R3 pop");
    do_reset();

    // R11 expression program
    mem[10] = 16'd7;  mem[11] = 16'd1000; mem[12] = 16'd300;
    mem[13] = 16'd250; mem[14] = 16'd9000; mem[15] = 16'd77;
    begin
      logic [W-1:0] exp_a;
      exp_a = mem[11] + mem[12] * mem[13] - mem[14] + mem[15] + mem[10];
      run_op(3'd0, 8'd12, "R11"); run_op(3'd0, 8'd13, "R11"); run_op(3'd4, 8'd0, "R11");
      run_op(3'd0, 8'd11, "R11"); run_op(3'd2, 8'd0, "R11"); run_op(3'd0, 8'd14, "R11");
      run_op(3'd3, 8'd0, "R11"); run_op(3'd0, 8'd15, "R11"); run_op(3'd2, 8'd0, "R11");
      run_op(3'd0, 8'd10, "R11"); run_op(3'd2, 8'd0, "R11"); run_op(3'd1, 8'd10, "R11");
      chk(mem[10] == exp_a, "R11 result", mem[10], exp_a);
    end

    // Random stream, reset every 60 instructions
    for (int k = 0; k < 600; k++) begin
      int r;
      logic [2:0] op;
      if (k % 60 == 0) do_reset();
      r = $urandom_range(0, 99);
      if (r < 38) op = 3'd0;
      else if (r < 52) op = 3'd1;
      else if (r < 66) op = 3'd2;
      else if (r < 79) op = 3'd3;
      else if (r < 93) op = 3'd4;
      else op = 3'(5 + $urandom_range(0, 2));
      run_op(op, 8'($urandom_range(0, 255)), "R2-random");
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule